// File: doc/BRIEF.md
# Status Register Write-Protection Controller

This block keeps the status byte of a small serial nonvolatile memory and rules on every write the memory's protocol engine wants to perform. It holds a volatile write-enable flag, mirrors a live busy indication, and keeps three nonvolatile control bits: a status-lock bit and a two-bit protected-region selector. The nonvolatile bits are ordinary flops whose reset value is a parameter, standing in for values that survive power cycles.

The protocol engine pulses strobes to set or clear the write-enable flag, presents a status-write request with its data byte, and presents an array address for which it wants a write permission. The block answers with two combinational grants, one for status writes and one for array writes, and publishes the status byte for read-back. An active-low protect pin, together with the lock bit, moves the block between a software-protected mode and a hardware-protected mode. While a write cycle is busy the stored control bits read back frozen, and the end of a busy cycle drops the write-enable flag.

Top module: `stat_prot_ctrl`

## Requirements
- R1: After synchronous reset the write-enable flag is 0 and, with default parameters, the status byte reads 0x00 and both grants are 0.
- R2: The status byte has the lock bit at bit 7, zeros at bits 6..4, the upper region bit at bit 3, the lower region bit at bit 2, the write-enable flag at bit 1 and the live busy input at bit 0.
- R3: A set strobe raises the write-enable flag on the next edge; a clear strobe lowers it and wins when both arrive together; a fall of the busy input lowers it on the edge that sees busy low.
- R4: With the lock bit at 0 a status write is granted whenever the flag is set and busy is low, whatever the protect pin; a granted write stores only data bits 7, 3 and 2, and a request without a grant stores nothing.
- R5: With the lock bit at 1 and the protect pin low, status writes are refused and leave the stored bits unchanged; raising the pin restores the grant.
- R6: The array grant is the flag, not busy, and an address outside the protected region; region selector 00 protects nothing, 01 the addresses whose two top bits are 11, 10 those whose top bit is 1, 11 every address.
- R7: While busy is high both grants are 0.
- R8: While busy is high bits 7, 3 and 2 of the status byte keep the values they had when busy rose; the newly stored values appear one edge after busy is seen low.
- R9: The nonvolatile bits take a parameterised value at reset; a non-zero setting shows in the status byte right after reset while the write-enable flag still reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wp_n | input | 1 | Protect pin, active low |
| wel_set | input | 1 | Pulse: raise write-enable flag |
| wel_clr | input | 1 | Pulse: lower write-enable flag |
| busy | input | 1 | High while a nonvolatile write cycle runs |
| sw_req | input | 1 | Status write request, one cycle |
| sw_data | input | 8 | Data byte of the status write |
| aw_addr | input | ADDR_W | Array address being queried |
| status | output | 8 | Read-back status byte |
| sw_allow | output | 1 | Status write grant |
| aw_allow | output | 1 | Array write grant for aw_addr |

## Verification
The assertions assume the protocol engine pulses strobes and status-write requests for single cycles, and that a granted write is followed by busy rather than by a second request, so the frozen read-back is checked only across busy windows the engine itself creates. The stimulus changes inputs only on the falling clock edge, raises busy one cycle after a granted request and drops it after a few cycles, and probes every region boundary with the exact first and last address of each protected span.

// File: rtl/stat_prot_pkg.sv
// Shared bit positions and the nonvolatile field type of the status controller.
// Assumes an 8-bit status byte.
package stat_prot_pkg;
    localparam int ST_W     = 8;
    localparam int LOCK_POS = 7;
    localparam int BPH_POS  = 3;
    localparam int BPL_POS  = 2;
    localparam int WEN_POS  = 1;
    localparam int BSY_POS  = 0;

    typedef struct packed {
        logic       lock;
        logic [1:0] region;
    } nv_bits_t;
endpackage

// File: rtl/prot_wel_latch.sv
// Volatile write-enable flag. Set by a strobe, cleared by a strobe (priority)
// or by the end of a busy cycle. Assumes busy is synchronous to clk.
module prot_wel_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic busy_i,
    output logic wel_o
);
    logic busy_q;
    logic wel_q;
    logic done;

    // Remember busy of the previous cycle to detect its fall.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= busy_i;
    end

    assign done = busy_q & ~busy_i;

    // Flag update: clear events dominate the set strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)              wel_q <= 1'b0;
        else if (clr_i || done)  wel_q <= 1'b0;
        else if (set_i)          wel_q <= 1'b1;
    end

    assign wel_o = wel_q;

    a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !wel_o);
    a_r3_busy_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !busy_i) |=> !wel_o);
endmodule

// File: rtl/prot_nv_store.sv
// Stores the lock bit and region selector (modelled nonvolatile bits with a
// parameterised reset value) and a read-back copy frozen while busy.
// Assumes wr_en_i is only raised on a granted status write.
module prot_nv_store
    import stat_prot_pkg::*;
#(
    parameter logic [2:0] NV_INIT = 3'b000
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en_i,
    input  nv_bits_t wr_data_i,
    input  logic     busy_i,
    output nv_bits_t stored_o,
    output nv_bits_t view_o
);
    nv_bits_t stored_q;
    nv_bits_t view_q;

    // Stored bits: take new data only on a granted write.
    always_ff @(posedge clk) begin
        if (!rst_n)       stored_q <= nv_bits_t'(NV_INIT);
        else if (wr_en_i) stored_q <= wr_data_i;
    end

    // Read-back copy: follows the stored bits only while not busy.
    always_ff @(posedge clk) begin
        if (!rst_n)       view_q <= nv_bits_t'(NV_INIT);
        else if (!busy_i) view_q <= stored_q;
    end

    assign stored_o = stored_q;
    assign view_o   = view_q;

    a_r8_frozen_view: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(view_q));
    a_r4_hold_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(stored_q));
endmodule

// File: rtl/prot_region.sv
// Decides whether an array address falls inside the protected region chosen
// by the two-bit selector: none, top quarter, top half or everything.
// Assumes ADDR_W >= 1; with a single bit the quarter collapses onto the half.
module prot_region #(
    parameter int ADDR_W = 13
) (
    input  logic [1:0]        region_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);
    localparam int TOP = ADDR_W - 1;

    logic in_half;
    logic in_quarter;

    assign in_half = addr_i[TOP];

    generate
        if (ADDR_W >= 2) begin : g_wide
            assign in_quarter = addr_i[TOP] & addr_i[TOP-1];
        end else begin : g_narrow
            assign in_quarter = addr_i[TOP];
        end
    endgenerate

    // Select the region test named by the selector.
    always_comb begin
        case (region_i)
            2'b00:   hit_o = 1'b0;
            2'b01:   hit_o = in_quarter;
            2'b10:   hit_o = in_half;
            default: hit_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/stat_prot_ctrl.sv
// Status register write-protection controller. Publishes the status byte and
// grants status and array writes from the write-enable flag, busy, the lock
// bit, the protect pin and the region selector. Assumes single-cycle strobes.
module stat_prot_ctrl
    import stat_prot_pkg::*;
#(
    parameter int         ADDR_W  = 13,
    parameter logic [2:0] NV_INIT = 3'b000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n,
    input  logic              wel_set,
    input  logic              wel_clr,
    input  logic              busy,
    input  logic              sw_req,
    input  logic [ST_W-1:0]   sw_data,
    input  logic [ADDR_W-1:0] aw_addr,
    output logic [ST_W-1:0]   status,
    output logic              sw_allow,
    output logic              aw_allow
);
    logic     wel;
    logic     hw_locked;
    logic     region_hit;
    logic     sw_take;
    nv_bits_t new_bits;
    nv_bits_t stored;
    nv_bits_t view;
    logic     unused_data;

    prot_wel_latch u_wel (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (wel_set),
        .clr_i  (wel_clr),
        .busy_i (busy),
        .wel_o  (wel)
    );

    // Pick the writable fields out of the request byte.
    always_comb begin
        new_bits.lock   = sw_data[LOCK_POS];
        new_bits.region = {sw_data[BPH_POS], sw_data[BPL_POS]};
    end

    assign unused_data = ^{sw_data[6:4], sw_data[WEN_POS], sw_data[BSY_POS]};

    assign hw_locked = stored.lock & ~wp_n;
    assign sw_allow  = wel & ~busy & ~hw_locked;
    assign sw_take   = sw_req & sw_allow;

    prot_nv_store #(.NV_INIT(NV_INIT)) u_nv (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (sw_take),
        .wr_data_i (new_bits),
        .busy_i    (busy),
        .stored_o  (stored),
        .view_o    (view)
    );

    prot_region #(.ADDR_W(ADDR_W)) u_region (
        .region_i (stored.region),
        .addr_i   (aw_addr),
        .hit_o    (region_hit)
    );

    assign aw_allow = wel & ~busy & ~region_hit;

    // Assemble the read-back byte.
    always_comb begin
        status           = '0;
        status[LOCK_POS] = view.lock;
        status[BPH_POS]  = view.region[1];
        status[BPL_POS]  = view.region[0];
        status[WEN_POS]  = wel;
        status[BSY_POS]  = busy;
    end

    a_r7_busy_denies: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!sw_allow && !aw_allow));
    a_r5_hw_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req && stored.lock && !wp_n) |=> $stable(stored));
    a_r6_whole_array: assert property (@(posedge clk) disable iff (!rst_n)
        (stored.region == 2'b11) |-> !aw_allow);
    a_r3_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (wel_set && !wel_clr && !busy && !$past(busy)) |=> status[WEN_POS]);
endmodule

// File: tb/stat_prot_ctrl_bench.sv
module stat_prot_ctrl_bench;
    localparam int AW = 13;

    typedef struct {
        string      req;
        logic [7:0] st;
        logic       sw;
        logic       aw;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wp_n = 1'b1;
    logic          wel_set = 1'b0;
    logic          wel_clr = 1'b0;
    logic          busy = 1'b0;
    logic          sw_req = 1'b0;
    logic [7:0]    sw_data = 8'h00;
    logic [AW-1:0] aw_addr = '0;
    logic [7:0]    status, status_b;
    logic          sw_allow, aw_allow, sw_allow_b, aw_allow_b;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    exp_t sb[$];

    always #4 clk = ~clk;

    stat_prot_ctrl #(.ADDR_W(AW)) u_stat_prot_ctrl (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .wel_set(wel_set),
        .wel_clr(wel_clr), .busy(busy), .sw_req(sw_req), .sw_data(sw_data),
        .aw_addr(aw_addr), .status(status), .sw_allow(sw_allow),
        .aw_allow(aw_allow));

    stat_prot_ctrl #(.ADDR_W(AW), .NV_INIT(3'b110)) u_stat_prot_ctrl_alt (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .wel_set(1'b0),
        .wel_clr(1'b0), .busy(1'b0), .sw_req(1'b0), .sw_data(8'h00),
        .aw_addr(aw_addr), .status(status_b), .sw_allow(sw_allow_b),
        .aw_allow(aw_allow_b));

    task automatic compare(string req, logic [7:0] st_a, logic sw_a, logic aw_a,
                           logic [7:0] st_e, logic sw_e, logic aw_e);
        checks++;
        if (st_a !== st_e || sw_a !== sw_e || aw_a !== aw_e) begin
            fails++;
            $display("FAIL %s: status=%h sw=%b aw=%b expected status=%h sw=%b aw=%b",
                     req, st_a, sw_a, aw_a, st_e, sw_e, aw_e);
        end
    endtask

    // Driver side: queue an expectation for the outputs as they stand now.
    task automatic expect_now(string req, logic [7:0] st, logic sw, logic aw);
        #1;
        sb.push_back('{req, st, sw, aw});
        #1;
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    // One-cycle pulse on a strobe group, ending at the next falling edge.
    task automatic pulse_set();
        @(negedge clk); wel_set = 1'b1;
        @(negedge clk); wel_set = 1'b0;
    endtask

    task automatic status_write(logic [7:0] d);
        @(negedge clk); sw_req = 1'b1; sw_data = d;
        @(negedge clk); sw_req = 1'b0; sw_data = 8'h00;
    endtask

    // Monitor: pop expectations and compare with the live outputs.
    initial begin
        forever begin
            exp_t it;
            wait (sb.size() != 0);
            it = sb.pop_front();
            compare(it.req, status, sw_allow, aw_allow, it.st, it.sw, it.aw);
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        expect_now("R1 reset state", 8'h00, 1'b0, 1'b0);
        compare("R9 nonzero reset value", status_b, sw_allow_b, aw_allow_b,
                8'h88, 1'b0, 1'b0);

        pulse_set();
        expect_now("R3 set strobe, R6 none protected", 8'h02, 1'b1, 1'b1);

        @(negedge clk); wel_set = 1'b1; wel_clr = 1'b1;
        @(negedge clk); wel_set = 1'b0; wel_clr = 1'b0;
        expect_now("R3 clear wins", 8'h00, 1'b0, 1'b0);

        pulse_set();
        wp_n = 1'b0;
        status_write(8'hFF);
        cycles(1);
        expect_now("R4 write with pin low, R2 layout", 8'h8E, 1'b0, 1'b0);

        status_write(8'h00);
        cycles(1);
        expect_now("R5 hardware lock ignores write", 8'h8E, 1'b0, 1'b0);
        aw_addr = 13'h0000;
        expect_now("R6 whole array protected", 8'h8E, 1'b0, 1'b0);

        @(negedge clk); wp_n = 1'b1;
        expect_now("R5 pin high restores grant", 8'h8E, 1'b1, 1'b0);

        @(negedge clk); sw_req = 1'b1; sw_data = 8'h08;
        @(negedge clk); sw_req = 1'b0; sw_data = 8'h00; busy = 1'b1;
        expect_now("R7 busy denies grants", 8'h8F, 1'b0, 1'b0);
        cycles(3);
        expect_now("R8 frozen read-back while busy", 8'h8F, 1'b0, 1'b0);
        busy = 1'b0;
        cycles(1);
        expect_now("R3 busy end clears flag, R8 new value shown", 8'h08, 1'b0, 1'b0);

        pulse_set();
        aw_addr = 13'h0FFF;
        expect_now("R6 half: below boundary", 8'h0A, 1'b1, 1'b1);
        aw_addr = 13'h1000;
        expect_now("R6 half: first protected", 8'h0A, 1'b1, 1'b0);

        status_write(8'h04);
        cycles(1);
        aw_addr = 13'h17FF;
        expect_now("R6 quarter: below boundary", 8'h06, 1'b1, 1'b1);
        aw_addr = 13'h1800;
        expect_now("R6 quarter: first protected", 8'h06, 1'b1, 1'b0);
        aw_addr = 13'h1FFF;
        expect_now("R6 quarter: last address", 8'h06, 1'b1, 1'b0);

        @(negedge clk); wel_clr = 1'b1;
        @(negedge clk); wel_clr = 1'b0; aw_addr = 13'h0000;
        expect_now("R6 flag needed for array write", 8'h04, 1'b0, 1'b0);
        status_write(8'h80);
        cycles(1);
        expect_now("R4 request without flag ignored", 8'h04, 1'b0, 1'b0);

        #4;
        wait (sb.size() == 0);
        #1;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule